// File: doc/BRIEF.md
# Prescaled Watchdog Timer with Sticky Reset Cause

This block is a watchdog for a system-on-chip, reached over a minimal 32-bit register bus made of an address, a write strobe, write data and combinational read data. A free-running 1 MHz timebase strobe (one clock-wide pulse per microsecond) feeds a programmable prescaler. The prescaler turns those pulses into watchdog ticks, and a 16-bit down-counter counts the ticks. Software arms the timer by writing a tick count into the load register and then setting the enable bit. While running, software keeps the system alive by writing the restart bit of the status register. If the count runs out while the timer is enabled, the block raises a single-cycle system reset request.

The same edge sets a sticky flag that shows the last reset came from the watchdog. Only the power-on reset clears that flag. The chip-level reset that the watchdog requests returns every other register to its idle state but leaves the flag alone, so boot software can read it afterwards. Both reset inputs are asynchronous and active-low, and each is released synchronously inside the block.

Top module: `wdg_prescaled_timer`

## Requirements
- R1: After power-on reset, the control, load, status and reset-cause registers all read 0, and `rst_req` is low.
- R2: The register offsets are fixed as follows. The status register is at 0x00, the control register at 0x20, the load register at 0x24 and the reset-cause register at 0x38. In the control register, bits [31:16] hold the prescaler value and bit 7 holds the enable, and every other bit reads 0. The load register reads back its last written value in bits [15:0], with the upper bits reading 0. The status register always reads 0.
- R3: While enabled, the prescaler emits one tick on every P-th timebase pulse, where P is the prescaler field. A value of 0 is treated as 1. Clock cycles without a timebase pulse do not advance it.
- R4: After a reload with load value L, the reset request is raised on the edge that delivers tick number max(L,1). `rst_req` is high in the cycle that follows that edge.
- R5: A control write that changes enable from 0 to 1 reloads both the down-counter and the prescaler count. A control write that leaves enable at 1 reloads neither.
- R6: A status write with bit 9 set reloads the down-counter and the prescaler count. If such a write lands on the same edge as a tick, the reload wins. A status write with bit 9 clear has no effect.
- R7: A load register write does not change a count already in progress. The new value is used only at the next kick or enable.
- R8: While enable is 0, nothing counts and no reset request is raised. A control write that clears enable on the same edge as the final tick suppresses the request.
- R9: Each expiry gives a reset request exactly one cycle long. No further request follows until the next reload.
- R10: A reset request sets bit 1 of the reset-cause register. That bit survives `sys_rst_n` and is cleared only by `por_n`. `sys_rst_n` clears enable, the prescaler field and the load value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, asynchronous, active-low; clears everything including the cause flag |
| sys_rst_n | input | 1 | Chip reset, asynchronous, active-low; clears everything except the cause flag |
| us_pulse | input | 1 | One-cycle strobe per microsecond of timebase |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-cycle system reset request on expiry |

## Verification
The hardest cases to reach are a register write and a tick that meet on the very same clock edge. Two such collisions matter: a kick against a tick, and clearing enable against the final tick. In both, the priority decides whether a reset request leaves the block. To hit these edges exactly, the bench holds the timebase strobe high on every cycle with a prescaler of 1, so every edge is a tick. It then drives the bus write from inside the cycle-counting loop at a chosen edge number. With the timebase strobe gated to every second or third cycle, the same loop shows that the prescaler counts pulses rather than clock cycles.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_LOAD  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_CAUSE = 8'h38;

  localparam int BIT_EN    = 7;
  localparam int BIT_KICK  = 9;
  localparam int PRESC_LSB = 16;
  localparam int BIT_CAUSE = 1;
endpackage

// File: rtl/wdg_rst_sync.sv
module wdg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int PRESC_W = 16,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               cause_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               en_o,
  output logic [PRESC_W-1:0] presc_o,
  output logic [CNT_W-1:0]   load_o,
  output logic               kick_o,
  output logic               en_rise_o,
  output logic               en_drop_o
);
  logic               ctrl_wr, load_wr, stat_wr;
  logic               en_q, en_d;
  logic [PRESC_W-1:0] presc_q, presc_d;
  logic [CNT_W-1:0]   load_q, load_d;

  assign ctrl_wr = we_i && (addr_i == OFS_CTRL);
  assign load_wr = we_i && (addr_i == OFS_LOAD);
  assign stat_wr = we_i && (addr_i == OFS_STAT);

  always_comb begin
    en_d    = en_q;
    presc_d = presc_q;
    load_d  = load_q;
    if (ctrl_wr) begin
      en_d    = wdata_i[BIT_EN];
      presc_d = wdata_i[PRESC_LSB +: PRESC_W];
    end
    if (load_wr) load_d = wdata_i[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      presc_q <= '0;
      load_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q    <= en_d;
        presc_q <= presc_d;
      end
      if (load_wr) load_q <= load_d;
    end
  end

  assign kick_o    = stat_wr && wdata_i[BIT_KICK];
  assign en_rise_o = ctrl_wr && wdata_i[BIT_EN] && !en_q;
  assign en_drop_o = ctrl_wr && !wdata_i[BIT_EN];
  assign en_o      = en_q;
  assign presc_o   = presc_q;
  assign load_o    = load_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CTRL: begin
        rdata_o[PRESC_LSB +: PRESC_W] = presc_q;
        rdata_o[BIT_EN]               = en_q;
      end
      OFS_LOAD:  rdata_o[CNT_W-1:0] = load_q;
      OFS_CAUSE: rdata_o[BIT_CAUSE] = cause_i;
      default:   rdata_o = '0;
    endcase
  end

  // R2
  ctrl_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (en_q == $past(wdata_i[BIT_EN])));
  // R7
  load_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> (load_q == $past(wdata_i[CNT_W-1:0])));
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int PRESC_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic               reload_i,
  input  logic               us_pulse_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               tick_o
);
  logic [PRESC_W-1:0] pcnt_q, pcnt_d;
  logic [PRESC_W-1:0] presc_eff;
  logic               step, hit;

  assign presc_eff = (presc_i == '0) ? PRESC_W'(1) : presc_i;
  assign step      = run_i && us_pulse_i;
  assign hit       = step && (pcnt_q >= presc_eff - PRESC_W'(1));

  always_comb begin
    pcnt_d = pcnt_q;
    if (reload_i)  pcnt_d = '0;
    else if (step) pcnt_d = hit ? '0 : pcnt_q + PRESC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pcnt_q <= '0;
    else if (reload_i || step) pcnt_q <= pcnt_d;
  end

  assign tick_o = hit && !reload_i;

  // R5
  presc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> (pcnt_q == '0));
  // R8
  presc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !reload_i) |=> $stable(pcnt_q));
endmodule

// File: rtl/wdg_downcount.sv
module wdg_downcount #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             en_i,
  input  logic             reload_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             exp_q, exp_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    exp_d  = 1'b0;
    if (reload_i) begin
      cnt_d  = load_i;
      done_d = 1'b0;
    end else if (tick_i && run_i && !done_q) begin
      if (cnt_q <= CNT_W'(1)) begin
        cnt_d  = '0;
        done_d = 1'b1;
        exp_d  = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      exp_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
      exp_q  <= exp_d;
    end
  end

  assign rst_req_o = exp_q;

  // R9
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);
  // R8
  req_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> $past(en_i));
  // R6
  cnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> (cnt_q == $past(load_i)));
  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdg_prescaled_timer.sv
module wdg_prescaled_timer
  import wdg_pkg::*;
#(
  parameter int PRESC_W     = 16,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              us_pulse,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  logic               core_arst_n, core_rst_n, por_sync_n;
  logic               en, kick, en_rise, en_drop, run, reload, tick;
  logic [PRESC_W-1:0] presc;
  logic [CNT_W-1:0]   load;
  logic               cause_q;

  assign core_arst_n = por_n & sys_rst_n;

  wdg_rst_sync #(.STAGES(SYNC_STAGES)) u_core_sync (
    .clk(clk), .arst_n(core_arst_n), .srst_n(core_rst_n));
  wdg_rst_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk(clk), .arst_n(por_n), .srst_n(por_sync_n));

  wdg_regs #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(core_rst_n),
    .addr_i(bus_addr), .we_i(bus_we), .wdata_i(bus_wdata),
    .cause_i(cause_q), .rdata_o(bus_rdata),
    .en_o(en), .presc_o(presc), .load_o(load),
    .kick_o(kick), .en_rise_o(en_rise), .en_drop_o(en_drop));

  assign run    = en && !en_drop;
  assign reload = kick || en_rise;

  wdg_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(core_rst_n), .run_i(run), .reload_i(reload),
    .us_pulse_i(us_pulse), .presc_i(presc), .tick_o(tick));

  wdg_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(core_rst_n), .run_i(run), .en_i(en),
    .reload_i(reload), .tick_i(tick), .load_i(load), .rst_req_o(rst_req));

  always_ff @(posedge clk or negedge por_sync_n) begin
    if (!por_sync_n)  cause_q <= 1'b0;
    else if (rst_req) cause_q <= 1'b1;
  end

  // R10
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!por_sync_n)
    cause_q |=> cause_q);
  // R10
  cause_set_chk: assert property (@(posedge clk) disable iff (!por_sync_n)
    rst_req |=> cause_q);
endmodule

// File: tb/wdg_prescaled_timer_tb.sv
module wdg_prescaled_timer_tb_top;
  localparam logic [7:0] A_STAT = 8'h00, A_CTRL = 8'h20, A_LOAD = 8'h24, A_CAUSE = 8'h38;

  // vector table: prescaler, load, pulse period, expected expiry edge
  localparam int NV = 6;
  localparam int TV_P   [NV] = '{1, 2, 0, 2, 3, 1};
  localparam int TV_L   [NV] = '{1, 3, 4, 2, 0, 5};
  localparam int TV_PER [NV] = '{1, 1, 1, 3, 2, 2};
  localparam int TV_EXP [NV] = '{1, 6, 4, 12, 6, 10};

  logic        clk = 1'b0;
  logic        por_n, sys_rst_n, us_pulse, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, rd;
  logic        rst_req;
  int          n_chk = 0, n_err = 0, first, pulses;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  wdg_prescaled_timer dut_i (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .us_pulse(us_pulse),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_req(rst_req));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    us_pulse = 1'b0; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #2;
    bus_we = 1'b0;
  endtask

  task automatic rdreg(input logic [7:0] a);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #2 rd = bus_rdata;
  endtask

  task automatic arm(input int p, input int l);
    wr(A_CTRL, 32'(p) << 16);
    wr(A_LOAD, 32'(l));
    wr(A_CTRL, (32'(p) << 16) | 32'h80);
  endtask

  // counts edges after the last write; an optional bus write lands on edge act_k
  task automatic run(input int per, input int lim, input int act_k,
                     input logic [7:0] act_a, input logic [31:0] act_d);
    first = -1; pulses = 0;
    for (int k = 1; k <= lim; k++) begin
      @(negedge clk);
      if (rst_req) begin
        pulses++;
        if (first < 0) first = k - 1;
      end
      us_pulse = ((k % per) == 0);
      if (k == act_k) begin
        bus_addr = act_a; bus_wdata = act_d; bus_we = 1'b1;
      end else begin
        bus_we = 1'b0;
      end
    end
    @(negedge clk);
    bus_we = 1'b0; us_pulse = 1'b0;
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finish_up();
  end

  initial begin
    por_n = 1'b0; sys_rst_n = 1'b1; us_pulse = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #2 por_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rdreg(A_CTRL);  check(rd == 0, "R1 ctrl", rd, 0);
    rdreg(A_LOAD);  check(rd == 0, "R1 load", rd, 0);
    rdreg(A_CAUSE); check(rd == 0, "R1 cause", rd, 0);
    check(rst_req == 0, "R1 rst_req", rst_req, 0);

    // R2 readback
    wr(A_CTRL, 32'hABCD_FF7F);
    rdreg(A_CTRL); check(rd == 32'hABCD_0000, "R2 ctrl", rd, 32'hABCD_0000);
    wr(A_LOAD, 32'h1234_5678);
    rdreg(A_LOAD); check(rd == 32'h0000_5678, "R2 load", rd, 32'h5678);
    wr(A_STAT, 32'h0000_0200);
    rdreg(A_STAT); check(rd == 0, "R2 stat", rd, 0);

    // R3 R4 R5 R9 table
    for (int v = 0; v < NV; v++) begin
      arm(TV_P[v], TV_L[v]);
      run(TV_PER[v], TV_EXP[v] + 4, 0, A_STAT, 0);
      check(first == TV_EXP[v], "R4 expiry edge", first, TV_EXP[v]);
      check(pulses == 1, "R9 single pulse", pulses, 1);
    end
    rdreg(A_CAUSE); check(rd == 32'h2, "R10 cause set", rd, 2);

    // R6 kick on a tick edge wins
    arm(1, 4);
    run(1, 12, 3, A_STAT, 32'h200);
    check(first == 7, "R6 kick reload", first, 7);

    // R6 status write without bit 9
    arm(1, 4);
    run(1, 10, 3, A_STAT, 32'hFFFF_FDFF);
    check(first == 4, "R6 no kick", first, 4);

    // R7 load write mid count, used at next enable
    arm(1, 4);
    run(1, 10, 2, A_LOAD, 32'd10);
    check(first == 4, "R7 load deferred", first, 4);
    wr(A_CTRL, 32'h0001_0000);
    wr(A_CTRL, 32'h0001_0080);
    run(1, 14, 0, A_STAT, 0);
    check(first == 10, "R7 load applied", first, 10);

    // R5 ctrl rewrite while enabled does not reload
    arm(2, 3);
    run(1, 10, 3, A_CTRL, 32'h0002_0080);
    check(first == 6, "R5 no reload", first, 6);

    // R8 disable on the final tick edge
    arm(1, 3);
    run(1, 20, 3, A_CTRL, 32'h0001_0000);
    check(pulses == 0, "R8 disable suppress", pulses, 0);

    // R8 disable mid count, R5 re-enable reloads full count
    arm(1, 5);
    run(1, 15, 2, A_CTRL, 32'h0001_0000);
    check(pulses == 0, "R8 disabled idle", pulses, 0);
    wr(A_CTRL, 32'h0001_0080);
    run(1, 10, 0, A_STAT, 0);
    check(first == 5, "R5 re-enable", first, 5);

    // R9 no repeat after expiry
    arm(1, 2);
    run(1, 30, 0, A_STAT, 0);
    check(pulses == 1, "R9 no repeat", pulses, 1);

    // R10 cause survives chip reset, cleared by power-on reset
    @(negedge clk) sys_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    sys_rst_n = 1'b1;
    repeat (4) @(posedge clk);
    rdreg(A_CAUSE); check(rd == 32'h2, "R10 cause kept", rd, 2);
    rdreg(A_CTRL);  check(rd == 0, "R10 ctrl cleared", rd, 0);
    rdreg(A_LOAD);  check(rd == 0, "R10 load cleared", rd, 0);
    @(negedge clk) por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    repeat (4) @(posedge clk);
    rdreg(A_CAUSE); check(rd == 0, "R10 cause cleared", rd, 0);

    finish_up();
  end
endmodule